// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

This block is a clocked model of a two-sided shared memory of 2048 words of 8 bits. Each side (left and right) has its own select, write strobe, output enable, 11-bit address and 8-bit write data. Both sides may touch any word in the same cycle. Reads return data one cycle after the address, qualified by a valid flag. The read stream has no ready input: a word is presented for exactly one cycle and the consumer must take it then, so there is no back-pressure.

When the two sides select the same word and at least one of them is writing, an arbiter picks a loser and raises that side's busy flag. A write from a busy side is dropped, while a read from a busy side still completes. The `is_master` pin picks the arbiter's role. When high, the busy flags are arbiter outputs. When low, the arbiter's result is discarded, the busy outputs stay low, and externally supplied busy inputs gate the writes instead. This lets a second device follow the first so that the word can be made wider.

The two top words serve as mailboxes. The very top word is the left side's inbox, and the word below it is the right side's inbox. When the opposite side writes an inbox, the owner's interrupt flag rises. It falls when the owner reads that word.

Top module: `dp_mailbox_ram`

## Requirements
- R1: A write accepted on either side at address A is returned by a later read of A on either side. The read data appears, with `*_rvalid` high, on the clock edge after the address is presented.
- R2: `*_rdata` is zero and `*_rvalid` is low in every cycle except the one that follows a read that had select high, write low and output enable high.
- R3: Both sides reading the same word in the same cycle raise no busy flag, and both sides receive the word.
- R4: Contention means both sides are selected on the same address and at least one of them is writing. An access starts when select rises or the address changes. Under contention, the side that started later sees busy. If neither side started in the current cycle, the previous loser keeps busy.
- R5: If both sides start contending accesses in the same cycle, the right side sees busy and the left side does not.
- R6: A write from a side whose effective busy is high leaves memory unchanged. A read from a busy side still returns the pre-write contents of the word.
- R7: The left interrupt is set by an accepted right-side write to address 0x7FF (all ones). It is cleared by a left-side read of that address. A left-side write there does not set it. If a set and a clear fall in the same cycle, the set wins.
- R8: The right interrupt is set by an accepted left-side write to address 0x7FE (all ones except bit 0). It is cleared by a right-side read of that address.
- R9: With `is_master` low, both busy outputs stay low, each side's busy input blocks that side's writes, and when both sides write the same word unblocked, the left value is stored.
- R10: A side with select low performs no write, returns no read data and touches neither interrupt.
- R11: While reset is low, on each clock edge, both interrupts, both valid flags and both read-data buses clear, and the busy outputs are held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| is_master | input | 1 | 1: busy flags come from the arbiter; 0: busy inputs are obeyed |
| l_cs | input | 1 | Left select |
| l_we | input | 1 | Left write strobe (1 write, 0 read) |
| l_oe | input | 1 | Left output enable |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, zero when not valid |
| l_rvalid | output | 1 | Left read data valid |
| l_busy_in | input | 1 | Left write block when `is_master` is low |
| l_busy_out | output | 1 | Left lost arbitration (master only) |
| l_irq | output | 1 | Left mailbox interrupt |
| r_cs | input | 1 | Right select |
| r_we | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, zero when not valid |
| r_rvalid | output | 1 | Right read data valid |
| r_busy_in | input | 1 | Right write block when `is_master` is low |
| r_busy_out | output | 1 | Right lost arbitration (master only) |
| r_irq | output | 1 | Right mailbox interrupt |

## Verification
Arbitration and the mailbox can fall in the same cycle. One side holds a write to an inbox while the owner starts a read of that inbox, so the owner is busy, its read clears and the write sets in the same edge. The bench drives this case and expects the interrupt to stay high and the owner to still receive the word. A second overlap is a busy reader of a word that the winner is writing. Here the bench expects the old word on the read bus and the new word on a later read. Memory contents are tracked in a bench-side array that is filled from an arithmetic pattern and swept over every address of a 16-word build.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  // Loser of the last arbitration: bit 0 left side, bit 1 right side
  typedef enum logic [1:0] {
    LOSE_NONE  = 2'b00,
    LOSE_LEFT  = 2'b01,
    LOSE_RIGHT = 2'b10
  } lose_e;

  localparam int unsigned SIDES = 2;
endpackage

// File: rtl/dpm_arbiter.sv
module dpm_arbiter
  import dpm_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SIDES-1:0]              cs,
  input  logic [SIDES-1:0]              we,
  input  logic [SIDES-1:0][AW-1:0]      addr,
  output logic [SIDES-1:0]              busy
);
  logic [SIDES-1:0]         prev_cs;
  logic [SIDES-1:0][AW-1:0] prev_addr;
  logic [SIDES-1:0]         fresh;
  logic                     contend;
  lose_e                    lose_q, lose_d;

  // an access is fresh when select rises or the address moves
  generate
    for (genvar s = 0; s < SIDES; s++) begin : g_fresh
      assign fresh[s] = cs[s] & (~prev_cs[s] | (addr[s] != prev_addr[s]));
    end
  endgenerate

  assign contend = cs[0] & cs[1] & (addr[0] == addr[1]) & (we[0] | we[1]);

  always_comb begin
    lose_d = LOSE_NONE;
    if (contend) begin
      if (fresh[1])                 lose_d = LOSE_RIGHT;  // right later, or tie
      else if (fresh[0])            lose_d = LOSE_LEFT;
      else if (lose_q != LOSE_NONE) lose_d = lose_q;      // standing decision
      else                          lose_d = LOSE_RIGHT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_cs   <= '0;
      prev_addr <= '0;
      lose_q    <= LOSE_NONE;
    end else begin
      prev_cs   <= cs;
      prev_addr <= addr;
      lose_q    <= lose_d;
    end
  end

  assign busy = lose_d;
endmodule

// File: rtl/dpm_store.sv
module dpm_store
  import dpm_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SIDES-1:0]         wr_en,
  input  logic [SIDES-1:0]         rd_en,
  input  logic [SIDES-1:0][AW-1:0] addr,
  input  logic [SIDES-1:0][DW-1:0] wdata,
  output logic [SIDES-1:0][DW-1:0] rdata,
  output logic [SIDES-1:0]         rvalid
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  // right first so that a left write to the same word lands last
  always_ff @(posedge clk) begin
    if (wr_en[1]) cells[addr[1]] <= wdata[1];
    if (wr_en[0]) cells[addr[0]] <= wdata[0];
  end

  // read-first registered outputs, zeroed when idle
  always_ff @(posedge clk) begin
    for (int s = 0; s < SIDES; s++) begin
      if (!rst_n) begin
        rdata[s]  <= '0;
        rvalid[s] <= 1'b0;
      end else if (rd_en[s]) begin
        rdata[s]  <= cells[addr[s]];
        rvalid[s] <= 1'b1;
      end else begin
        rdata[s]  <= '0;
        rvalid[s] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dpm_mailbox.sv
module dpm_mailbox #(
  parameter int unsigned     AW  = 11,
  parameter logic [AW-1:0]   BOX = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          own_cs,
  input  logic          own_we,
  input  logic [AW-1:0] own_addr,
  input  logic          peer_wr,
  input  logic [AW-1:0] peer_addr,
  output logic          irq
);
  logic post, take;

  assign post = peer_wr & (peer_addr == BOX);
  assign take = own_cs & ~own_we & (own_addr == BOX);

  always_ff @(posedge clk) begin
    if (!rst_n)    irq <= 1'b0;
    else if (post) irq <= 1'b1;
    else if (take) irq <= 1'b0;
  end
endmodule

// File: rtl/dp_mailbox_ram.sv
module dp_mailbox_ram
  import dpm_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_master,
  input  logic          l_cs,
  input  logic          l_we,
  input  logic          l_oe,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_rvalid,
  input  logic          l_busy_in,
  output logic          l_busy_out,
  output logic          l_irq,
  input  logic          r_cs,
  input  logic          r_we,
  input  logic          r_oe,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_rvalid,
  input  logic          r_busy_in,
  output logic          r_busy_out,
  output logic          r_irq
);
  localparam logic [AW-1:0] BOX_LEFT  = {AW{1'b1}};
  localparam logic [AW-1:0] BOX_RIGHT = {{(AW-1){1'b1}}, 1'b0};

  logic [SIDES-1:0]         cs, we, oe;
  logic [SIDES-1:0][AW-1:0] addr;
  logic [SIDES-1:0][DW-1:0] wdata, rdata;
  logic [SIDES-1:0]         rvalid, arb_busy, ext_busy, eff_busy;
  logic [SIDES-1:0]         wr_en, rd_en, irq;

  assign cs       = {r_cs, l_cs};
  assign we       = {r_we, l_we};
  assign oe       = {r_oe, l_oe};
  assign addr     = {r_addr, l_addr};
  assign wdata    = {r_wdata, l_wdata};
  assign ext_busy = {r_busy_in, l_busy_in};

  dpm_arbiter #(.AW(AW)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .cs    (cs),
    .we    (we),
    .addr  (addr),
    .busy  (arb_busy)
  );

  assign eff_busy = is_master ? arb_busy : ext_busy;
  assign wr_en    = cs & we & ~eff_busy & {SIDES{rst_n}};
  assign rd_en    = cs & ~we & oe;

  dpm_store #(.AW(AW), .DW(DW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .rvalid (rvalid)
  );

  generate
    for (genvar s = 0; s < SIDES; s++) begin : g_box
      localparam logic [AW-1:0] BOX = (s == 0) ? BOX_LEFT : BOX_RIGHT;
      dpm_mailbox #(.AW(AW), .BOX(BOX)) u_box (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_cs    (cs[s]),
        .own_we    (we[s]),
        .own_addr  (addr[s]),
        .peer_wr   (wr_en[SIDES-1-s]),
        .peer_addr (addr[SIDES-1-s]),
        .irq       (irq[s])
      );
    end
  endgenerate

  assign l_rdata    = rdata[0];
  assign r_rdata    = rdata[1];
  assign l_rvalid   = rvalid[0];
  assign r_rvalid   = rvalid[1];
  assign l_busy_out = rst_n & is_master & arb_busy[0];
  assign r_busy_out = rst_n & is_master & arb_busy[1];
  assign l_irq      = irq[0];
  assign r_irq      = irq[1];
endmodule

// File: rtl/dpm_checker.sv
module dpm_checker #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          is_master,
  input logic          l_cs,
  input logic          l_we,
  input logic          l_oe,
  input logic [AW-1:0] l_addr,
  input logic [DW-1:0] l_rdata,
  input logic          l_rvalid,
  input logic          l_busy_out,
  input logic          l_irq,
  input logic          r_cs,
  input logic          r_we,
  input logic          r_oe,
  input logic [AW-1:0] r_addr,
  input logic [DW-1:0] r_rdata,
  input logic          r_rvalid,
  input logic          r_busy_in,
  input logic          r_busy_out,
  input logic          r_irq
);
  localparam logic [AW-1:0] BOX_LEFT = {AW{1'b1}};

  // R2
  l_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_rvalid |-> $past(l_cs && l_oe && !l_we));
  // R2
  r_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_rvalid |-> $past(r_cs && r_oe && !r_we));
  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_rvalid |-> l_rdata == '0) and (!r_rvalid |-> r_rdata == '0));
  // R4
  one_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({l_busy_out, r_busy_out}));
  // R5
  tie_right_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && l_cs && r_cs && l_addr == r_addr && (l_we || r_we)
     && !$past(l_cs) && !$past(r_cs)) |-> (r_busy_out && !l_busy_out));
  // R7
  l_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l_irq) |-> $past(r_cs && r_we && r_addr == BOX_LEFT
                           && !(is_master ? r_busy_out : r_busy_in)));
  // R9
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> (!l_busy_out && !r_busy_out));
  // R11
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!l_irq && !r_irq && !l_rvalid && !r_rvalid));
endmodule

bind dp_mailbox_ram dpm_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .is_master  (is_master),
  .l_cs       (l_cs),
  .l_we       (l_we),
  .l_oe       (l_oe),
  .l_addr     (l_addr),
  .l_rdata    (l_rdata),
  .l_rvalid   (l_rvalid),
  .l_busy_out (l_busy_out),
  .l_irq      (l_irq),
  .r_cs       (r_cs),
  .r_we       (r_we),
  .r_oe       (r_oe),
  .r_addr     (r_addr),
  .r_rdata    (r_rdata),
  .r_rvalid   (r_rvalid),
  .r_busy_in  (r_busy_in),
  .r_busy_out (r_busy_out),
  .r_irq      (r_irq)
);

// File: tb/dp_mailbox_ram_bench.sv
module dp_mailbox_ram_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int BOXL = DEPTH - 1;
  localparam int BOXR = DEPTH - 2;

  logic clk = 1'b0;
  logic rst_n, is_master;
  logic l_cs, l_we, l_oe, l_busy_in, r_cs, r_we, r_oe, r_busy_in;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_rvalid, r_rvalid, l_busy_out, r_busy_out, l_irq, r_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [DEPTH];

  always #2 clk = ~clk;

  dp_mailbox_ram #(.AW(AW), .DW(DW)) u_dp_mailbox_ram (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .l_cs(l_cs), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_busy_in(l_busy_in),
    .l_busy_out(l_busy_out), .l_irq(l_irq),
    .r_cs(r_cs), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_busy_in(r_busy_in),
    .r_busy_out(r_busy_out), .r_irq(r_irq)
  );

  function automatic logic [DW-1:0] pat(int a, int k);
    return DW'((a * 29 + k * 71 + 5) & 255);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drv_l(logic cs, logic we, logic oe, int a, int d);
    l_cs = cs; l_we = we; l_oe = oe; l_addr = AW'(a); l_wdata = DW'(d);
  endtask

  task automatic drv_r(logic cs, logic we, logic oe, int a, int d);
    r_cs = cs; r_we = we; r_oe = oe; r_addr = AW'(a); r_wdata = DW'(d);
  endtask

  task automatic quiet();
    drv_l(0, 0, 0, 0, 0);
    drv_r(0, 0, 0, 0, 0);
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // read a word through the right side and compare with the model
  task automatic peek_r(int a, string req);
    drv_r(1, 0, 1, a, 0);
    cyc();
    chk({req, " rvalid"}, int'(r_rvalid), 1);
    chk({req, " data"}, int'(r_rdata), int'(model[a]));
    drv_r(0, 0, 0, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0; is_master = 1'b1; l_busy_in = 1'b0; r_busy_in = 1'b0;
    quiet();
    repeat (3) cyc();
    // R11 reset state
    chk("R11 l_irq", int'(l_irq), 0);
    chk("R11 r_irq", int'(r_irq), 0);
    chk("R11 valids", int'({l_rvalid, r_rvalid}), 0);
    chk("R11 rdata", int'({l_rdata, r_rdata}), 0);
    chk("R11 busy", int'({l_busy_out, r_busy_out}), 0);
    rst_n = 1'b1;
    cyc();

    // R1 sweep: left writes every word
    for (int a = 0; a < DEPTH; a++) begin
      drv_l(1, 1, 0, a, pat(a, 0));
      model[a] = pat(a, 0);
      cyc();
    end
    quiet();
    cyc();
    chk("R8 right irq set by left write", int'(r_irq), 1);
    chk("R7 own write leaves left irq", int'(l_irq), 0);
    for (int a = 0; a < DEPTH; a++) peek_r(a, "R1 right read");
    cyc();
    chk("R8 right irq cleared by read", int'(r_irq), 0);
    chk("R2 idle rvalid", int'(r_rvalid), 0);

    // R3 shared reads, every word
    for (int a = 0; a < DEPTH; a++) begin
      drv_l(1, 0, 1, a, 0);
      drv_r(1, 0, 1, a, 0);
      #1;
      chk("R3 busy", int'({l_busy_out, r_busy_out}), 0);
      cyc();
      chk("R3 left data", int'(l_rdata), int'(model[a]));
      chk("R3 right data", int'(r_rdata), int'(model[a]));
    end
    quiet();
    cyc();

    // R1 sweep in the other direction
    for (int a = 0; a < DEPTH; a++) begin
      drv_r(1, 1, 0, a, pat(a, 1));
      model[a] = pat(a, 1);
      cyc();
    end
    quiet();
    cyc();
    chk("R7 left irq set by right write", int'(l_irq), 1);
    for (int a = 0; a < DEPTH; a++) begin
      drv_l(1, 0, 1, a, 0);
      cyc();
      chk("R1 left data", int'(l_rdata), int'(model[a]));
      chk("R1 left rvalid", int'(l_rvalid), 1);
    end
    quiet();
    cyc();
    chk("R7 left irq cleared by read", int'(l_irq), 0);

    // R2 output enable low, and write with oe high
    drv_l(1, 0, 0, 3, 0);
    drv_r(1, 1, 1, 4, pat(4, 1));
    cyc();
    chk("R2 oe low rvalid", int'(l_rvalid), 0);
    chk("R2 oe low rdata", int'(l_rdata), 0);
    chk("R2 write rvalid", int'(r_rvalid), 0);

    // R10 deselected sides
    drv_l(0, 1, 1, 5, 8'hEE);
    drv_r(0, 1, 0, BOXL, 8'h3C);
    cyc();
    chk("R10 no read", int'(l_rvalid), 0);
    chk("R10 no irq", int'(l_irq), 0);
    quiet();
    peek_r(5, "R10 no write");
    cyc();

    // R5 tie: both start writing word 7
    drv_l(1, 1, 0, 7, 8'h11);
    drv_r(1, 1, 0, 7, 8'h22);
    #1;
    chk("R5 right busy", int'(r_busy_out), 1);
    chk("R5 left free", int'(l_busy_out), 0);
    model[7] = 8'h11;
    cyc();
    #1;
    chk("R4 standing loser", int'(r_busy_out), 1);
    cyc();
    quiet();
    cyc();
    peek_r(7, "R5 left value kept");
    cyc();

    // R6 busy reader still gets the old word
    drv_l(1, 1, 0, 8, 8'h33);
    drv_r(1, 0, 1, 8, 0);
    #1;
    chk("R6 reader busy", int'(r_busy_out), 1);
    cyc();
    chk("R6 busy read valid", int'(r_rvalid), 1);
    chk("R6 busy read old", int'(r_rdata), int'(model[8]));
    model[8] = 8'h33;
    quiet();
    cyc();
    peek_r(8, "R6 winner write");
    cyc();

    // R4 right starts later
    drv_l(1, 0, 1, 9, 0);
    cyc();
    drv_r(1, 1, 0, 9, 8'h44);
    #1;
    chk("R4 late right busy", int'(r_busy_out), 1);
    chk("R4 early left free", int'(l_busy_out), 0);
    cyc();
    quiet();
    #1;
    chk("R4 busy drops", int'({l_busy_out, r_busy_out}), 0);
    cyc();
    peek_r(9, "R6 blocked right write");
    cyc();

    // R4 left starts later
    drv_r(1, 0, 1, 10, 0);
    cyc();
    drv_l(1, 1, 0, 10, 8'h55);
    #1;
    chk("R4 late left busy", int'(l_busy_out), 1);
    chk("R4 early right free", int'(r_busy_out), 0);
    cyc();
    quiet();
    cyc();
    peek_r(10, "R6 blocked left write");
    cyc();

    // R7 set beats clear
    drv_r(1, 1, 0, BOXL, 8'h66);
    model[BOXL] = 8'h66;
    cyc();
    chk("R7 set", int'(l_irq), 1);
    drv_l(1, 0, 1, BOXL, 0);
    #1;
    chk("R7 owner busy", int'(l_busy_out), 1);
    cyc();
    chk("R7 set wins", int'(l_irq), 1);
    chk("R7 busy read data", int'(l_rdata), 8'h66);
    drv_r(0, 0, 0, 0, 0);
    cyc();
    chk("R7 read alone clears", int'(l_irq), 0);
    quiet();
    cyc();

    // R9 slave mode
    is_master = 1'b0;
    cyc();
    drv_l(1, 1, 0, 11, 8'h77);
    drv_r(1, 1, 0, 11, 8'h88);
    #1;
    chk("R9 busy outs low", int'({l_busy_out, r_busy_out}), 0);
    model[11] = 8'h77;
    cyc();
    l_busy_in = 1'b1;
    drv_l(1, 1, 0, 12, 8'h99);
    drv_r(0, 0, 0, 0, 0);
    cyc();
    l_busy_in = 1'b0;
    r_busy_in = 1'b1;
    drv_l(0, 0, 0, 0, 0);
    drv_r(1, 1, 0, BOXL, 8'hAA);
    cyc();
    chk("R9 blocked write no irq", int'(l_irq), 0);
    r_busy_in = 1'b0;
    quiet();
    cyc();
    peek_r(11, "R9 left wins");
    peek_r(12, "R9 left blocked");
    peek_r(BOXL, "R9 right blocked");
    is_master = 1'b1;
    cyc();

    // R11 reset mid-run
    drv_l(1, 1, 0, BOXR, 8'h12);
    drv_r(1, 1, 0, BOXL, 8'h34);
    cyc();
    chk("R11 pre irqs", int'({l_irq, r_irq}), 3);
    drv_l(1, 0, 1, 0, 0);
    drv_r(0, 0, 0, 0, 0);
    rst_n = 1'b0;
    cyc();
    chk("R11 irqs cleared", int'({l_irq, r_irq}), 0);
    chk("R11 rvalid cleared", int'(l_rvalid), 0);
    chk("R11 rdata cleared", int'(l_rdata), 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule